// File: doc/BRIEF.md
# Target Reset and Debug-Entry Sequencer

This block decides when a debug probe pulls the target's reset line and when it forces the target into debug mode after a start request. A request starts a timed sequence. Reset is pulled low for a set number of millisecond ticks and then released. A settle delay follows before any contact with the target. What happens next depends on the startup mode:

- **Halt mode** asks for a halt at once.
- **Stop mode** first lets the target run its own code for a bounded run window, then asks for a halt.
- **Run mode** leaves the target running and ends the sequence.

After a halt, the block sends a one-cycle strobe that starts the initialisation list.

All timing is counted in ticks of an external millisecond strobe. The mode and the three time values are captured when a request is accepted. The reset output is a pull-down enable only. A live drive-enable input can stop the block from ever pulling reset, and the sequence timing stays the same when it does.

Top module: `rds_rst_seq`

## Requirements
- R1: After reset, `tgt_rst_oe_o`, `halt_req_o`, `init_start_o` and `busy_o` are all low.
- R2: When a halt-mode or stop-mode sequence ends, `halt_req_o` is high for exactly one cycle and `init_start_o` is high in the cycle straight after it, for one cycle.
- R3: Reset is driven starting the cycle after a request is accepted. It stays driven until the edge after the edge that counts the N-th tick, where N = `pulse_ms_i`. A value of 0 selects a width of 3 ticks.
- R4: After release, N = `wake_ms_i` ticks are counted the same way before the next step (halt, run window or end). With a tick every cycle, the delay phase lasts N+1 cycles.
- R5: In stop mode, a run window of `run_ms_i` ticks comes after the delay phase and before the halt. Values below 100 count as 100, and values above 32000 count as 32000.
- R6: In run mode, the sequence ends after the delay phase with no halt and no init strobe.
- R7: While `drive_en_i` is 0, `tgt_rst_oe_o` stays low. All other timing is unchanged.
- R8: `busy_o` is high from the cycle after acceptance up to and including the halt cycle, or up to the end of the delay phase in run mode. A request is accepted only while `busy_o` is low; a request made while busy has no effect.
- R9: The mode and the three time values are captured on acceptance. Changes to them later in the sequence have no effect.
- R10: The 2-bit mode encoding is 0 = halt, 1 = stop, 2 = run. Code 3 behaves as halt mode.
- R11: `halt_req_o` and `init_start_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle strobe, once per millisecond |
| start_i | input | 1 | Sequence request |
| mode_i | input | 2 | Startup mode (0 halt, 1 stop, 2 run, 3 as halt) |
| pulse_ms_i | input | 16 | Reset width in ticks, 0 selects 3 |
| wake_ms_i | input | 16 | Delay after release in ticks |
| run_ms_i | input | 16 | Stop-mode run window in ticks, clamped to 100..32000 |
| drive_en_i | input | 1 | When 0, the reset line is never pulled |
| tgt_rst_oe_o | output | 1 | Pull-down enable for the target reset line |
| halt_req_o | output | 1 | One-cycle request to force debug entry |
| init_start_o | output | 1 | One-cycle strobe to start the init list |
| busy_o | output | 1 | Sequence in progress |

## Verification
Suppose the phase register or the tick counter goes wrong. The reset pull-down or `busy_o` then shows it at the ports within one tick period, as an edge that is early, late or missing. A wrong captured mode shows up as a strobe where none was expected, or a missing one, at the end of the delay phase. A clamp fault can only be seen as a stop-mode busy interval of the wrong length, so the run window is tested below, inside and above its range. A cycle-accurate model runs alongside the design and compares every output on every clock, across continuous and sparse tick patterns.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'd0,
    MODE_STOP = 2'd1,
    MODE_RUN  = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RST    = 3'd1,
    PH_WAKE   = 3'd2,
    PH_RUNWIN = 3'd3,
    PH_HALT   = 3'd4,
    PH_INIT   = 3'd5
  } phase_e;
endpackage

// File: rtl/rds_cfg.sv
module rds_cfg
  import rds_pkg::*;
#(
  parameter int TIME_W       = 16,
  parameter int DEF_PULSE_MS = 3,
  parameter int RUN_MIN_MS   = 100,
  parameter int RUN_MAX_MS   = 32000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        mode_i,
  input  logic [TIME_W-1:0] pulse_i,
  input  logic [TIME_W-1:0] wake_i,
  input  logic [TIME_W-1:0] run_i,
  output mode_e             mode_o,
  output logic [TIME_W-1:0] pulse_o,
  output logic [TIME_W-1:0] wake_o,
  output logic [TIME_W-1:0] run_o
);
  localparam logic [TIME_W-1:0] PULSE_DEF = TIME_W'(DEF_PULSE_MS);
  localparam logic [TIME_W-1:0] RUN_LO    = TIME_W'(RUN_MIN_MS);
  localparam logic [TIME_W-1:0] RUN_HI    = TIME_W'(RUN_MAX_MS);

  mode_e             mode_n;
  logic [TIME_W-1:0] pulse_n, run_n;

  always_comb begin
    mode_n  = (mode_i == 2'd3) ? MODE_HALT : mode_e'(mode_i);
    pulse_n = (pulse_i == '0) ? PULSE_DEF : pulse_i;
    if (run_i < RUN_LO)      run_n = RUN_LO;
    else if (run_i > RUN_HI) run_n = RUN_HI;
    else                     run_n = run_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_HALT;
      pulse_o <= PULSE_DEF;
      wake_o  <= '0;
      run_o   <= RUN_LO;
    end else if (load_i) begin
      mode_o  <= mode_n;
      pulse_o <= pulse_n;
      wake_o  <= wake_i;
      run_o   <= run_n;
    end
  end
endmodule

// File: rtl/rds_ms_timer.sv
module rds_ms_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] target_i,
  output logic              done_o
);
  logic [TIME_W-1:0] cnt_q;

  assign done_o = (cnt_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rds_rst_seq.sv
module rds_rst_seq
  import rds_pkg::*;
#(
  parameter int TIME_W       = 16,
  parameter int DEF_PULSE_MS = 3,
  parameter int RUN_MIN_MS   = 100,
  parameter int RUN_MAX_MS   = 32000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [TIME_W-1:0] pulse_ms_i,
  input  logic [TIME_W-1:0] wake_ms_i,
  input  logic [TIME_W-1:0] run_ms_i,
  input  logic              drive_en_i,
  output logic              tgt_rst_oe_o,
  output logic              halt_req_o,
  output logic              init_start_o,
  output logic              busy_o
);
  phase_e            ph_q, ph_d;
  mode_e             mode_q;
  logic [TIME_W-1:0] pulse_tgt, wake_tgt, run_tgt, tgt;
  logic              accept, clr, done;

  assign accept = start_i && ((ph_q == PH_IDLE) || (ph_q == PH_INIT));

  rds_cfg #(
    .TIME_W(TIME_W), .DEF_PULSE_MS(DEF_PULSE_MS),
    .RUN_MIN_MS(RUN_MIN_MS), .RUN_MAX_MS(RUN_MAX_MS)
  ) u_cfg (
    .clk_i, .rst_ni, .load_i(accept), .mode_i,
    .pulse_i(pulse_ms_i), .wake_i(wake_ms_i), .run_i(run_ms_i),
    .mode_o(mode_q), .pulse_o(pulse_tgt), .wake_o(wake_tgt), .run_o(run_tgt)
  );

  always_comb begin
    case (ph_q)
      PH_RST:    tgt = pulse_tgt;
      PH_WAKE:   tgt = wake_tgt;
      PH_RUNWIN: tgt = run_tgt;
      default:   tgt = '0;
    endcase
  end

  rds_ms_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i, .rst_ni, .clear_i(clr), .tick_i(ms_tick_i),
    .target_i(tgt), .done_o(done)
  );

  always_comb begin
    ph_d = ph_q;
    clr  = 1'b0;
    case (ph_q)
      PH_IDLE, PH_INIT: begin
        ph_d = PH_IDLE;
        if (accept) begin
          ph_d = PH_RST;
          clr  = 1'b1;
        end
      end
      PH_RST: if (done) begin
        ph_d = PH_WAKE;
        clr  = 1'b1;
      end
      PH_WAKE: if (done) begin
        clr = 1'b1;
        case (mode_q)
          MODE_RUN:  ph_d = PH_IDLE;
          MODE_STOP: ph_d = PH_RUNWIN;
          default:   ph_d = PH_HALT;
        endcase
      end
      PH_RUNWIN: if (done) ph_d = PH_HALT;
      PH_HALT:   ph_d = PH_INIT;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // pull-down enable only; the line is never driven high here
  assign tgt_rst_oe_o = (ph_q == PH_RST) && drive_en_i;
  assign halt_req_o   = (ph_q == PH_HALT);
  assign init_start_o = (ph_q == PH_INIT);
  assign busy_o       = (ph_q == PH_RST) || (ph_q == PH_WAKE) ||
                        (ph_q == PH_RUNWIN) || (ph_q == PH_HALT);
endmodule

// File: rtl/rds_rst_seq_chk.sv
module rds_rst_seq_chk #(
  parameter int TIME_W     = 16,
  parameter int RUN_MIN_MS = 100,
  parameter int RUN_MAX_MS = 32000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              drive_en_i,
  input logic              tgt_rst_oe_o,
  input logic              halt_req_o,
  input logic              init_start_o,
  input logic              busy_o,
  input logic [TIME_W-1:0] run_tgt_i
);
  AST_HALT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |=> !halt_req_o); // R2
  AST_HALT_THEN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |=> init_start_o); // R2
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_oe_o |-> busy_o); // R3
  AST_RUN_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tgt_i >= TIME_W'(RUN_MIN_MS)) && (run_tgt_i <= TIME_W'(RUN_MAX_MS))); // R5
  AST_NO_PULL_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_i |-> !tgt_rst_oe_o); // R7
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R8
  AST_BUSY_AT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> busy_o); // R8
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_req_o && init_start_o)); // R11
endmodule

bind rds_rst_seq rds_rst_seq_chk #(
  .TIME_W(TIME_W), .RUN_MIN_MS(RUN_MIN_MS), .RUN_MAX_MS(RUN_MAX_MS)
) u_chk (
  .clk_i, .rst_ni, .start_i, .drive_en_i, .tgt_rst_oe_o, .halt_req_o,
  .init_start_o, .busy_o, .run_tgt_i(run_tgt)
);

// File: tb/rds_rst_seq_bench.sv
module rds_rst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, start = 1'b0, drv = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [TW-1:0] pulse = '0, wake = '0, run = '0;
  logic rst_oe, halt, init, busy;
  int checks = 0, errors = 0;
  int tick_period = 1, tick_cnt = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rds_rst_seq u_rds_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .start_i(start),
    .mode_i(mode), .pulse_ms_i(pulse), .wake_ms_i(wake), .run_ms_i(run),
    .drive_en_i(drv), .tgt_rst_oe_o(rst_oe), .halt_req_o(halt),
    .init_start_o(init), .busy_o(busy)
  );

  assign tick = (tick_cnt == 0);
  always @(negedge clk) tick_cnt <= (tick_cnt + 1 >= tick_period) ? 0 : tick_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 reset,2 wake,3 run window,4 halt,5 init
  int m_ph = 0, m_left = 0, m_mode = 0, m_wake = 0, m_run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0, 5: begin
          if (start) begin
            m_mode = (mode == 2'd3) ? 0 : int'(mode);
            m_left = (pulse == 0) ? 3 : int'(pulse);
            m_wake = int'(wake);
            m_run  = (int'(run) < 100) ? 100 : (int'(run) > 32000) ? 32000 : int'(run);
            m_ph = 1;
          end else m_ph = 0;
        end
        1, 2, 3: begin
          if (m_left == 0) begin
            if (m_ph == 1) begin m_ph = 2; m_left = m_wake; end
            else if (m_ph == 2) begin
              if (m_mode == 2) m_ph = 0;
              else if (m_mode == 1) begin m_ph = 3; m_left = m_run; end
              else m_ph = 4;
            end else m_ph = 4;
          end else if (tick) m_left--;
        end
        4: m_ph = 5;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk({cur_req, " R3 reset pull"}, int'(rst_oe), int'(m_ph == 1 && drv));
    chk({cur_req, " R2 halt strobe"}, int'(halt), int'(m_ph == 4));
    chk({cur_req, " R2 init strobe"}, int'(init), int'(m_ph == 5));
    chk({cur_req, " R8 busy"}, int'(busy), int'(m_ph >= 1 && m_ph <= 4));
  end

  task automatic run_seq(input string tag, input int md, input int pl, input int wk,
                         input int rn, input bit disturb,
                         output int n_rst, output int n_busy, output int n_halt,
                         output int n_init, output int n_wake);
    cur_req = tag;
    n_rst = 0; n_busy = 0; n_halt = 0; n_init = 0; n_wake = 0;
    @(negedge clk);
    mode = 2'(md); pulse = TW'(pl); wake = TW'(wk); run = TW'(rn); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (i > 0) @(negedge clk);
      n_rst  += int'(rst_oe);
      n_busy += int'(busy);
      n_halt += int'(halt);
      n_init += int'(init);
      if (busy && !rst_oe && !halt && n_rst > 0) n_wake++;
      if (disturb && i == 2) begin mode = 2'd2; pulse = 16'd20; start = 1'b1; end
      if (disturb && i == 3) start = 1'b0;
      if (!busy) break;
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      n_halt += int'(halt);
      n_init += int'(init);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: actual busy %0d expected 0", int'(busy));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r, b, h, n, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", int'(rst_oe), 0); chk("R1 halt", int'(halt), 0);
    chk("R1 init", int'(init), 0); chk("R1 busy", int'(busy), 0);

    run_seq("R2", 0, 5, 4, 0, 1'b0, r, b, h, n, w);
    chk("R3 width", r, 6); chk("R4 delay", w, 5); chk("R8 busy len", b, 12);
    chk("R2 halt", h, 1); chk("R2 init", n, 1);

    run_seq("R3", 0, 0, 0, 0, 1'b0, r, b, h, n, w);
    chk("R3 default width", r, 4);

    run_seq("R5", 1, 2, 0, 50, 1'b0, r, b, h, n, w);
    chk("R5 low clamp", b, 106); chk("R5 halt", h, 1);
    run_seq("R5", 1, 2, 0, 150, 1'b0, r, b, h, n, w);
    chk("R5 in range", b, 156);
    run_seq("R5", 1, 2, 0, 32767, 1'b0, r, b, h, n, w);
    chk("R5 high clamp", b, 32006); chk("R11 init", n, 1);

    run_seq("R6", 2, 2, 3, 0, 1'b0, r, b, h, n, w);
    chk("R6 busy len", b, 7); chk("R6 no halt", h, 0); chk("R6 no init", n, 0);

    run_seq("R10", 3, 1, 1, 0, 1'b0, r, b, h, n, w);
    chk("R10 halt", h, 1); chk("R10 busy len", b, 5);

    drv = 1'b0;
    run_seq("R7", 0, 5, 4, 0, 1'b0, r, b, h, n, w);
    chk("R7 no pull", r, 0); chk("R7 busy len", b, 12);
    drv = 1'b1;

    run_seq("R9", 0, 5, 4, 0, 1'b1, r, b, h, n, w);
    chk("R9 width", r, 6); chk("R9 busy len", b, 12); chk("R9 halt", h, 1);

    tick_period = 3;
    run_seq("R4", 0, 2, 1, 0, 1'b0, r, b, h, n, w);
    chk("R4 sparse halt", h, 1);
    tick_period = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule